// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads two table entries from memory, one after the other. A caller presents a virtual address and the byte address of a root table. The walker reads one 32-bit entry from that root table. The entry names the 4 KB frame that holds a second table. The walker then reads one entry from the second table, and that entry names the data frame. The frame number sits above the untouched 12-bit page offset to form the result. If either entry is marked unmapped, the walk ends early and reports a fault.

All memory traffic goes through one read port with a request handshake and a response strobe. At most one read is in flight at any time. The caller sees a one-cycle completion pulse. The physical address and the fault flag that go with it stay on the outputs until the next request is taken.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, and `done`, `fault`, `mem_req_valid` and `paddr` are all 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while the walker is idle. Any `req_valid` raised during a walk is ignored, and the reads and result still belong to the request that was taken.
- R3: The first read goes to `root + 4 * vaddr[31:22]`.
- R4: The second read goes to `(first entry bits 31:12) * 4096 + 4 * vaddr[21:12]`.
- R5: An entry is valid when bit 0 is 1. Bits 31:12 hold the frame number, and bits 11:1 are ignored. When both entries are valid, `paddr` = `{second entry bits 31:12, vaddr[11:0]}` and `fault` = 0. `done` is high for exactly one cycle per walk.
- R6: If the first entry has bit 0 = 0, the walk issues exactly one read. It then raises `done` with `fault` = 1 and `paddr` = 0, and `fault` never rises without `done`.
- R7: If the second entry has bit 0 = 0, the walk issues exactly two reads. It then raises `done` with `fault` = 1 and `paddr` = 0.
- R8: After a read handshake (`mem_req_valid` and `mem_req_ready` both 1), no new read is requested until `mem_rsp_valid` has returned the data.
- R9: `paddr` and `fault` stay unchanged from the `done` pulse until the next request is taken.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted next cycle with the same `mem_req_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Byte address of the first-level table |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last walk hit an unmapped entry |
| paddr | output | 32 | Physical address of the last walk |

## Verification
Each walk is observed through the order and addresses of its memory reads, so errors in the walker's state show up at the ports right away:
- A wrong index slice or base shows up at the first or second read address, in the cycle that read is issued.
- A skipped or extra state changes the number of reads per walk.
- A lost handshake hold changes `mem_req_addr` while a read is stalled.

A corrupted result register shows up when `done` rises. If it corrupts later, it shows up as a change in `paddr` or `fault` during the idle cycles after the walk. The entries deliberately carry random values in bits 11:1, so a decoder that reads the wrong bit is exposed by either a false fault or a missed one.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD1  = 3'd1,
    ST_WT1  = 3'd2,
    ST_RD2  = 3'd3,
    ST_WT2  = 3'd4,
    ST_END  = 3'd5
  } walk_state_e;

endpackage

// File: rtl/pt_slot_addr.sv
module pt_slot_addr #(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned ENT_SH = 2
) (
  input  logic [PA_W-1:0]  base,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  addr
);

  logic [PA_W-1:0] offset;

  // Entry offset inside the table: index scaled by the entry size.
  assign offset = PA_W'(idx) << ENT_SH;
  assign addr   = base + offset;

endmodule

// File: rtl/pt_pte_decode.sv
module pt_pte_decode #(
  parameter int unsigned PTE_W     = 32,
  parameter int unsigned FRAME_W   = 20,
  parameter int unsigned VALID_BIT = 0
) (
  input  logic [PTE_W-1:0]   pte,
  output logic               ok,
  output logic [FRAME_W-1:0] frame
);

  logic unused_pte_bits;

  assign ok    = pte[VALID_BIT];
  assign frame = pte[PTE_W-1 -: FRAME_W];
  // Flag and reserved bits are not interpreted.
  assign unused_pte_bits = ^pte;

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        pte_ok,
  output walk_state_e state
);

  walk_state_e state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (req_valid)     state_nx = ST_RD1;
      ST_RD1:  if (mem_req_ready) state_nx = ST_WT1;
      ST_WT1:  if (mem_rsp_valid) state_nx = pte_ok ? ST_RD2 : ST_END;
      ST_RD2:  if (mem_req_ready) state_nx = ST_WT2;
      ST_WT2:  if (mem_rsp_valid) state_nx = ST_END;
      ST_END:                     state_nx = ST_IDLE;
      default:                    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned PTE_W     = 32,
  parameter int unsigned VALID_BIT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PA_W-1:0]  req_root,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic             fault,
  output logic [PA_W-1:0]  paddr
);

  localparam int unsigned LEVELS  = 2;
  localparam int unsigned FRAME_W = PA_W - OFF_W;
  localparam int unsigned ENT_SH  = $clog2(PTE_W / 8);

  walk_state_e        state;
  logic               accept;
  logic               rsp_l1;
  logic               rsp_l2;
  logic               pte_ok;
  logic [FRAME_W-1:0] pte_frame;

  logic [VA_W-1:0]    va_q;
  logic [PA_W-1:0]    root_q;
  logic [FRAME_W-1:0] tbl_frame_q;
  logic [PA_W-1:0]    paddr_q;
  logic               fault_q;

  logic [PA_W-1:0]    lvl_base [LEVELS];
  logic [PA_W-1:0]    lvl_addr [LEVELS];

  // Sequencer
  pt_walk_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .pte_ok        (pte_ok),
    .state         (state)
  );

  // Entry field extraction on the returned word
  pt_pte_decode #(
    .PTE_W     (PTE_W),
    .FRAME_W   (FRAME_W),
    .VALID_BIT (VALID_BIT)
  ) u_dec (
    .pte   (mem_rsp_data),
    .ok    (pte_ok),
    .frame (pte_frame)
  );

  // Table bases per level: root for level 0, looked-up frame for level 1
  assign lvl_base[0] = root_q;
  assign lvl_base[1] = {tbl_frame_q, {OFF_W{1'b0}}};

  // One entry-address unit per level; level g uses the g-th index field from the top
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    pt_slot_addr #(
      .PA_W   (PA_W),
      .IDX_W  (IDX_W),
      .ENT_SH (ENT_SH)
    ) u_addr (
      .base (lvl_base[g]),
      .idx  (va_q[OFF_W + (LEVELS - g) * IDX_W - 1 -: IDX_W]),
      .addr (lvl_addr[g])
    );
  end

  // Handshake decode
  assign accept = req_valid && (state == ST_IDLE);
  assign rsp_l1 = mem_rsp_valid && (state == ST_WT1);
  assign rsp_l2 = mem_rsp_valid && (state == ST_WT2);

  // Request registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      root_q <= '0;
    end else if (accept) begin
      va_q   <= req_vaddr;
      root_q <= req_root;
    end
  end

  // Second-level table frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_frame_q <= '0;
    end else if (rsp_l1 && pte_ok) begin
      tbl_frame_q <= pte_frame;
    end
  end

  // Result registers: cleared on accept, written when the walk ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
    end else if (accept) begin
      paddr_q <= '0;
    end else if (rsp_l2 && pte_ok) begin
      paddr_q <= {pte_frame, va_q[OFF_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
    end else if (accept) begin
      fault_q <= 1'b0;
    end else if ((rsp_l1 || rsp_l2) && !pte_ok) begin
      fault_q <= 1'b1;
    end
  end

  // Outputs
  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_RD1) || (state == ST_RD2);
  assign mem_req_addr  = (state == ST_RD2) ? lvl_addr[1] : lvl_addr[0];
  assign done          = (state == ST_END);
  assign fault         = fault_q;
  assign paddr         = paddr_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            done,
  input logic            fault,
  input logic [PA_W-1:0] paddr
);

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R8
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  fault_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> done);

  // R9
  result_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && !req_valid |=> $stable(paddr) && $stable(fault));

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done          (done),
  .fault         (fault),
  .paddr         (paddr)
);

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [31:0] req_root;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done;
  logic        fault;
  logic [31:0] paddr;

  int checks = 0;
  int errors = 0;

  pt_walker u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_root      (req_root),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .done          (done),
    .fault         (fault),
    .paddr         (paddr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Memory model
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [$];
  int          pend;
  logic [31:0] pend_addr;
  bit          hold_chk;
  logic [31:0] hold_addr;

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    pend = 0;
    hold_chk = 1'b0;
    pend_addr = '0;
    hold_addr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_rd(pend_addr);
        end
      end
      if (hold_chk) begin
        // R10: stalled request stays with its address
        check(mem_req_valid && mem_req_addr == hold_addr, "R10 stalled read", mem_req_addr, hold_addr);
        hold_chk = 1'b0;
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (rst_n && mem_req_valid) begin
        // R8: no request while a read is in flight
        check(pend == 0 && !mem_rsp_valid, "R8 outstanding read", 32'(pend), 32'h0);
        if (mem_req_ready) begin
          rd_log.push_back(mem_req_addr);
          pend_addr = mem_req_addr;
          pend = 1 + int'($urandom % 3);
        end else begin
          hold_chk  = 1'b1;
          hold_addr = mem_req_addr;
        end
      end
    end
  end

  // Expected-value functions
  function automatic logic [31:0] exp_a1(input logic [31:0] va, input logic [31:0] root);
    return root + {20'h0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] exp_a2(input logic [31:0] va, input logic [19:0] l2fr);
    return {l2fr, 12'h0} + {20'h0, va[21:12], 2'b00};
  endfunction

  // kind: 0 mapped, 1 first-level unmapped, 2 second-level unmapped
  task automatic walk(input logic [31:0] va, input logic [31:0] root, input logic [19:0] l2fr,
                      input logic [19:0] dfr, input int kind, input bit noise);
    logic [31:0] a1, a2, exp_pa, pa0;
    int          cyc, nreads, idle;
    bit          busy_bad, f0;
    a1 = exp_a1(va, root);
    a2 = exp_a2(va, l2fr);
    exp_pa = (kind == 0) ? {dfr, va[11:0]} : 32'h0;
    nreads = (kind == 1) ? 1 : 2;
    mem.delete();
    mem[a1] = {l2fr, 11'($urandom), kind != 1};
    if (kind != 1) mem[a2] = {dfr, 11'($urandom), kind != 2};

    @(negedge clk);
    rd_log.delete();
    req_vaddr = va;
    req_root  = root;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_bad = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin
      if (req_ready) busy_bad = 1'b1;
      if (noise) begin
        req_valid = 1'($urandom);
        req_vaddr = $urandom;
        req_root  = $urandom;
      end
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    check(cyc < 200, "R5 walk completion", 32'(cyc), 32'd200);
    check(!busy_bad, "R2 ready during walk", 32'(busy_bad), 32'h0);
    check(fault == (kind != 0), (kind == 1) ? "R6 fault" : (kind == 2) ? "R7 fault" : "R5 fault",
          32'(fault), 32'(kind != 0));
    check(paddr == exp_pa, (kind == 0) ? "R5 paddr" : "R6/R7 paddr", paddr, exp_pa);
    check(rd_log.size() == nreads, (kind == 1) ? "R6 read count" : "R7 read count",
          32'(rd_log.size()), 32'(nreads));
    if (rd_log.size() > 0) check(rd_log[0] == a1, "R3 first read address", rd_log[0], a1);
    if (nreads == 2 && rd_log.size() > 1) check(rd_log[1] == a2, "R4 second read address", rd_log[1], a2);
    pa0 = paddr;
    f0  = fault;
    @(negedge clk);
    check(!done, "R5 done pulse width", 32'(done), 32'h0);
    idle = 1 + int'($urandom % 4);
    for (int i = 0; i < idle; i++) @(negedge clk);
    check(paddr == pa0 && fault == f0, "R9 result held", paddr, pa0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'h5EED_0042);
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    req_root  = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready && !done && !fault && !mem_req_valid && paddr == 0, "R1 reset outputs",
          {req_ready, done, fault, mem_req_valid, paddr[27:0]}, 32'h8000_0000);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !mem_req_valid && !done, "R1 after release", 32'(req_ready), 32'h1);

    // Directed corners
    walk(32'h0000_0000, 32'h0000_0000, 20'h80000, 20'h00001, 0, 1'b0);
    walk(32'hFFFF_FFFF, 32'h000F_F000, 20'hFFFFF, 20'hFFFFF, 0, 1'b0);
    walk(32'h1234_5678, 32'h0004_2000, 20'h80123, 20'h0ABCD, 1, 1'b0);
    walk(32'h89AB_CDEF, 32'h0007_7000, 20'h8FEDC, 20'h13579, 2, 1'b1);

    // Random walks
    for (int n = 0; n < 60; n++) begin
      logic [31:0] va, root;
      logic [19:0] l2fr, dfr;
      int k;
      va   = $urandom;
      root = {12'h0, 8'($urandom), 12'h0};
      l2fr = {1'b1, 19'($urandom)};
      dfr  = 20'($urandom);
      k    = int'($urandom % 4);
      if (k == 3) k = 0;
      walk(va, root, l2fr, dfr, k, 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule